// File: doc/BRIEF.md
# Transponder identity frame serializer

This block turns a set of parallel animal-identification fields into a 128-bit frame and sends it one bit at a time. The fields are an animal flag, a 14-bit reserved code, an additional-data flag, a 10-bit country code, a 38-bit national code and a 24-bit extension value. The block puts a synchronisation header at the start of the frame. It adds a 16-bit CRC computed over the 64-bit identification code. It also inserts a stuffing one after every 8-bit payload group, so the header pattern can never appear inside the payload.

An internal bit-period sequencer advances the frame position once every `CLKS_PER_BIT` clocks of the carrier-derived clock. While `enable` is high, frames follow each other with no gap. The field inputs are captured only when a frame starts, so a frame never mixes old and new values. The outputs are a serial data bit and a one-clock frame-start marker. A line encoder downstream turns them into the modulation waveform.

Top module: `idframe_ser`

## Requirements
- R1: While `rst_n` is low, or while `enable` is low, both `ser_bit` and `frame_start` read 0. From one clock after `enable` is sampled low, both outputs stay at 0.
- R2: On the first clock edge that samples `enable` high while idle, a frame begins. From that edge, `frame_start` is 1 for exactly one clock, aligned with frame position 0, and is 0 at every other position of the frame.
- R3: Every frame position is held on `ser_bit` for exactly `CLKS_PER_BIT` (default 32) consecutive clocks.
- R4: Frame positions 0 to 9 (0-based, in send order) are 0, and position 10 is 1.
- R5: The identification code is built with the animal flag as code bit 0, the reserved code as bits 14:1, the additional-data flag as bit 15, the country code as bits 25:16 and the national code as bits 63:26. Code bit 8g+j is sent at position 11+9g+j, for group g in 0..7 and j in 0..7.
- R6: Position 19+9k is 1 for k in 0..12. This stuffing bit follows each of the 13 payload groups and ends at position 127.
- R7: The CRC is computed over the 64 code bits in send order, bit 0 first. It is an LSB-first shift register with reflected polynomial 0x8408 (x^16+x^12+x^5+1) and initial value 0x0000. CRC bit 8g+j is sent at position 83+9g+j, for g in 0..1.
- R8: Extension bit 8g+j is sent at position 101+9g+j, for g in 0..2.
- R9: With `enable` held high, consecutive `frame_start` pulses are exactly 128*`CLKS_PER_BIT` clocks apart. The frame content repeats when the inputs are unchanged.
- R10: Field inputs are captured only at a frame start. A change in mid-frame leaves the current frame untouched and appears in the next frame.
- R11: Dropping `enable` in mid-frame abandons that frame. When `enable` returns, a new frame starts from position 0 and carries the field values present at the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the frame stream while high |
| animal_flag | input | 1 | Animal application flag |
| reserved_code | input | 14 | Reserved code field |
| extra_flag | input | 1 | Additional-data flag |
| country_code | input | 10 | Numeric country code |
| national_code | input | 38 | National identification number |
| ext_value | input | 24 | Extension payload |
| ser_bit | output | 1 | Serial frame bit, LSB of each field first |
| frame_start | output | 1 | One-clock marker on frame position 0 |

## Verification
The hardest states to reach from the ports are a change of field values partway through a frame and a drop of `enable` partway through a frame. Both must be timed against the internal bit position, which the ports do not show. The bench counts clocks from the observed frame-start pulse and switches the fields at a chosen bit, 60 of the frame. It then checks that the captured frame matches the old values and the following frame matches the new ones. For the abort case, it disables the block several hundred clocks into a frame, changes the fields, re-enables, and checks that a full, correct frame with the new values starts one clock later.

// File: rtl/idframe_ser.sv
module idframe_ser #(
  parameter int CLKS_PER_BIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        animal_flag,
  input  logic [13:0] reserved_code,
  input  logic        extra_flag,
  input  logic [9:0]  country_code,
  input  logic [37:0] national_code,
  input  logic [23:0] ext_value,
  output logic        ser_bit,
  output logic        frame_start
);
  localparam int FRAME_BITS = 128;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int HDR_ZEROS  = 10;
  localparam int GROUP_W    = 8;
  localparam int SLOT_W     = GROUP_W + 1;
  localparam int PAY_BITS   = 64 + 16 + 24;
  localparam int GROUPS     = PAY_BITS / GROUP_W;
  localparam int PAY_START  = HDR_ZEROS + 1;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;

  logic [63:0]           id_code;
  logic [15:0]           crc_val;
  logic [PAY_BITS-1:0]   payload;
  logic [FRAME_BITS-1:0] frame_next;
  logic [FRAME_BITS-1:0] frame_q;
  logic [DIV_W-1:0]      div_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  running_q;
  logic                  bit_end;
  logic                  last_bit;

  function automatic logic [15:0] crc_of(input logic [63:0] d);
    logic [15:0] c;
    logic [63:0] s;
    c = '0;
    s = d;
    for (int i = 0; i < 64; i++) begin
      if (c[0] ^ s[0]) c = (c >> 1) ^ CRC_POLY_REF;
      else             c = c >> 1;
      s = s >> 1;
    end
    return c;
  endfunction

  assign id_code = {national_code, country_code, extra_flag, reserved_code, animal_flag};
  assign crc_val = crc_of(id_code);
  assign payload = {ext_value, crc_val, id_code};

  assign frame_next[HDR_ZEROS:0] = {1'b1, {HDR_ZEROS{1'b0}}};
  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    assign frame_next[PAY_START + SLOT_W*g +: GROUP_W] = payload[GROUP_W*g +: GROUP_W];
    assign frame_next[PAY_START + SLOT_W*g + GROUP_W]  = 1'b1;
  end

  assign bit_end  = (div_q == DIV_W'(CLKS_PER_BIT - 1));
  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      div_q     <= '0;
      idx_q     <= '0;
      frame_q   <= '0;
    end else if (!enable) begin
      running_q <= 1'b0;
      div_q     <= '0;
      idx_q     <= '0;
    end else if (!running_q) begin
      running_q <= 1'b1;
      div_q     <= '0;
      idx_q     <= '0;
      frame_q   <= frame_next;
    end else if (bit_end) begin
      div_q <= '0;
      idx_q <= idx_q + 1'b1;
      if (last_bit) frame_q <= frame_next;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign ser_bit     = running_q & frame_q[idx_q];
  assign frame_start = running_q && (idx_q == '0) && (div_q == '0);
endmodule

// File: rtl/idframe_ser_chk.sv
module idframe_ser_chk #(
  parameter int CLKS_PER_BIT = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       running,
  input logic [6:0] idx,
  input logic       ser_bit,
  input logic       frame_start
);
  localparam int PERIOD = 128 * CLKS_PER_BIT;

  logic is_stuff;
  logic seen_q;
  int   gap_q;

  assign is_stuff = (int'(idx) >= 19) && (((int'(idx) - 19) % 9) == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      gap_q  <= 0;
    end else if (!enable) begin
      seen_q <= 1'b0;
      gap_q  <= 0;
    end else if (frame_start) begin
      seen_q <= 1'b1;
      gap_q  <= 0;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ser_bit && !frame_start));                       // R1
  AST_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !running) |=> frame_start);                         // R2
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);                                 // R2
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && idx == $past(idx)) |-> $stable(ser_bit)); // R3
  AST_HEADER_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && idx < 7'd10) |-> !ser_bit);                        // R4
  AST_HEADER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && idx == 7'd10) |-> ser_bit);                        // R4
  AST_STUFF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && is_stuff) |-> ser_bit);                            // R6
  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && seen_q) |-> (gap_q == PERIOD - 1));            // R9
endmodule

bind idframe_ser idframe_ser_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .running     (running_q),
  .idx         (idx_q),
  .ser_bit     (ser_bit),
  .frame_start (frame_start)
);

// File: tb/idframe_ser_tb.sv
module idframe_ser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLKS       = 32;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        animal_flag = 1'b0;
  logic [13:0] reserved_code = '0;
  logic        extra_flag = 1'b0;
  logic [9:0]  country_code = '0;
  logic [37:0] national_code = '0;
  logic [23:0] ext_value = '0;
  logic        ser_bit;
  logic        frame_start;

  logic        alt_animal;
  logic [13:0] alt_reserved;
  logic        alt_extra;
  logic [9:0]  alt_country;
  logic [37:0] alt_national;
  logic [23:0] alt_ext;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  idframe_ser #(.CLKS_PER_BIT(CLKS)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .animal_flag   (animal_flag),
    .reserved_code (reserved_code),
    .extra_flag    (extra_flag),
    .country_code  (country_code),
    .national_code (national_code),
    .ext_value     (ext_value),
    .ser_bit       (ser_bit),
    .frame_start   (frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  function automatic logic [15:0] ref_crc(input logic [63:0] id);
    logic [15:0] c;
    c = 16'h0000;
    for (int k = 0; k < 64; k++) begin
      logic fb;
      fb = c[0] ^ id[k];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic logic [63:0] ref_id();
    return {national_code, country_code, extra_flag, reserved_code, animal_flag};
  endfunction

  function automatic logic [127:0] ref_frame();
    logic [63:0]  id;
    logic [103:0] pay;
    logic [127:0] f;
    int p;
    id  = ref_id();
    pay = {ext_value, ref_crc(id), id};
    f = '0;
    p = 0;
    for (int h = 0; h < 10; h++) begin f[p] = 1'b0; p++; end
    f[p] = 1'b1; p++;
    for (int k = 0; k < 104; k++) begin
      f[p] = pay[k]; p++;
      if (k % 8 == 7) begin f[p] = 1'b1; p++; end
    end
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_fields(input logic a, input logic [13:0] r, input logic x,
                            input logic [9:0] c, input logic [37:0] n, input logic [23:0] e);
    animal_flag = a; reserved_code = r; extra_flag = x;
    country_code = c; national_code = n; ext_value = e;
  endtask

  task automatic apply_alt();
    set_fields(alt_animal, alt_reserved, alt_extra, alt_country, alt_national, alt_ext);
  endtask

  task automatic restart();
    enable = 1'b0;
    tick();
    enable = 1'b1;
    tick();
  endtask

  task automatic capture(output logic [127:0] got, output int bad_hold,
                         output int extra_starts, input int change_at);
    got = '0; bad_hold = 0; extra_starts = 0;
    for (int b = 0; b < 128; b++) begin
      got[b] = ser_bit;
      for (int c = 0; c < CLKS; c++) begin
        if (ser_bit !== got[b]) bad_hold++;
        if (frame_start && !(b == 0 && c == 0)) extra_starts++;
        if (b == change_at && c == 0) apply_alt();
        tick();
      end
    end
  endtask

  task automatic t_reset();
    tick();
    check(ser_bit === 1'b0 && frame_start === 1'b0, "R1", "outputs in reset",
          {frame_start, ser_bit}, 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_idle();
    int bad;
    bad = 0;
    set_fields(1'b1, 14'h3fff, 1'b1, 10'h3ff, '1, '1);
    for (int i = 0; i < 40; i++) begin
      if (ser_bit !== 1'b0 || frame_start !== 1'b0) bad++;
      tick();
    end
    check(bad == 0, "R1", "idle outputs nonzero cycles", bad, 0);
  endtask

  task automatic t_zero_frame();
    logic [127:0] got, exp;
    int hold, starts;
    set_fields(1'b0, '0, 1'b0, '0, '0, '0);
    restart();
    check(frame_start === 1'b1, "R2", "frame_start after enable", frame_start, 1);
    exp = ref_frame();
    capture(got, hold, starts, -1);
    check(got[10:0] == 11'h400, "R4", "header", got[10:0], 11'h400);
    check(got == exp, "R6", "zero-field frame stuffing", got, exp);
    check(hold == 0, "R3", "bit hold violations", hold, 0);
    check(starts == 0, "R2", "extra frame_start pulses", starts, 0);
    check(frame_start === 1'b1, "R9", "next frame_start after 4096 clocks", frame_start, 1);
  endtask

  task automatic t_pattern();
    logic [127:0] got, exp;
    logic [15:0] gcrc, ecrc;
    logic [23:0] gext;
    int hold, starts;
    set_fields(1'b1, 14'h2a5c, 1'b1, 10'h384, 38'h2b_c0de_1234, 24'ha5c3f0);
    restart();
    exp  = ref_frame();
    ecrc = ref_crc(ref_id());
    capture(got, hold, starts, -1);
    check(got[11] == 1'b1, "R5", "animal flag at position 11", got[11], 1);
    check(got[82:11] == exp[82:11], "R5", "identification code bits", got[82:11], exp[82:11]);
    for (int j = 0; j < 8; j++) begin
      gcrc[j]     = got[83 + j];
      gcrc[8 + j] = got[92 + j];
    end
    check(gcrc == ecrc, "R7", "crc field", gcrc, ecrc);
    for (int g = 0; g < 3; g++)
      for (int j = 0; j < 8; j++) gext[8*g + j] = got[101 + 9*g + j];
    check(gext == ext_value, "R8", "extension field", gext, ext_value);
    check(got == exp, "R6", "full patterned frame", got, exp);
    check(hold == 0, "R3", "bit hold violations", hold, 0);
  endtask

  task automatic t_repeat();
    logic [127:0] g1, g2, exp;
    int hold, starts;
    set_fields(1'b0, 14'h0155, 1'b0, 10'h0f6, 38'h00_0000_0001, 24'h000000);
    restart();
    exp = ref_frame();
    capture(g1, hold, starts, -1);
    check(frame_start === 1'b1, "R9", "back-to-back start", frame_start, 1);
    capture(g2, hold, starts, -1);
    check(g1 == exp && g2 == exp, "R9", "repeated frames", g2, exp);
    check(starts == 0, "R2", "extra frame_start in second frame", starts, 0);
  endtask

  task automatic t_midchange();
    logic [127:0] got, exp_old, exp_new;
    int hold, starts;
    set_fields(1'b1, 14'h0001, 1'b0, 10'h2c4, 38'h12_3456_789a, 24'h00ff00);
    restart();
    exp_old = ref_frame();
    alt_animal = 1'b0; alt_reserved = 14'h1abc; alt_extra = 1'b1;
    alt_country = 10'h155; alt_national = 38'h3f_0f0f_0f0f; alt_ext = 24'h123456;
    capture(got, hold, starts, 60);
    exp_new = ref_frame();
    check(got == exp_old, "R10", "frame unaffected by mid-frame change", got, exp_old);
    check(frame_start === 1'b1, "R10", "next frame begins", frame_start, 1);
    capture(got, hold, starts, -1);
    check(got == exp_new, "R10", "new values in following frame", got, exp_new);
  endtask

  task automatic t_abort();
    logic [127:0] got, exp;
    int hold, starts;
    set_fields(1'b0, 14'h3333, 1'b1, 10'h001, 38'h0a_aaaa_aaaa, 24'hfedcba);
    restart();
    for (int i = 0; i < 530; i++) tick();
    enable = 1'b0;
    tick();
    check(ser_bit === 1'b0 && frame_start === 1'b0, "R11", "outputs after abort",
          {frame_start, ser_bit}, 0);
    for (int i = 0; i < 10; i++) tick();
    set_fields(1'b1, 14'h0000, 1'b0, 10'h3e7, 38'h00_0012_d687, 24'h000000);
    enable = 1'b1;
    tick();
    check(frame_start === 1'b1, "R11", "restart at position 0", frame_start, 1);
    exp = ref_frame();
    capture(got, hold, starts, -1);
    check(got == exp, "R11", "frame after restart", got, exp);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_zero_frame();
    t_pattern();
    t_repeat();
    t_midchange();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > WD_LIMIT);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule